// File: doc/BRIEF.md
# Transmit Frame Statistics Counter Bank

This block keeps per-event statistics for the transmit side of an Ethernet MAC. The transmitter issues a one-cycle status strobe when each frame finishes. The strobe carries the frame length in bytes and several flags: FCS good, number of collisions, abort after excessive collisions, MAC control frame, and pause honored. In the same cycle the block sorts the frame into size and error classes and advances every counter that applies. One status event can advance several counters at once. The total-collision counter adds the collision count of the frame rather than one.

Each counter has a sticky carry bit that is set when the counter wraps. Each carry bit also has a mask bit. A single interrupt line is raised while any carry bit is set and unmasked. A flat register port gives software access to the counters, the carry vector and the mask vector. Reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `txstat_bank`

## Requirements
- R1: A frame shorter than 64 bytes advances the undersize counter (address 7) when its FCS is good, and the fragment counter (address 8) when its FCS is bad. A frame of exactly 64 bytes advances neither counter.
- R2: A frame longer than 1518 bytes advances the oversize counter (address 6) when its FCS is good, and the jabber counter (address 3) when its FCS is bad. A frame of exactly 1518 bytes advances neither counter.
- R3: The FCS-error counter (address 4) advances only for frames of 64 to 1518 bytes whose FCS is bad.
- R4: The control-frame counter (address 5) advances for frames of 64 to 1518 bytes that carry the control flag, whatever their FCS.
- R5: The pause counter (address 2) advances for a frame of 64 to 1518 bytes that has a good FCS, the control flag and the pause-honored flag. It does not advance for any other frame.
- R6: The excessive-collision counter (address 0) advances by one for each status event whose abort flag is set.
- R7: The total-collision counter (address 1) advances by the collision count of the frame. A count of zero leaves it unchanged.
- R8: The register map is as follows:
  - Addresses 0 to 8 hold the counters, read zero-extended.
  - Address 9 holds the carry vector, in which bit i belongs to counter i.
  - Address 10 holds the mask vector.
  - Counters reset to 0 and load the write data when written.
  - Addresses 11 to 15 read 0, and writes to them have no effect.
- R9: A counter that wraps past its all-ones value sets its carry bit. For the total-collision counter, a carry out of its adder also sets the carry bit. Writing 1 to a carry bit clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as the clear keeps the bit set.
- R10: The mask vector resets to all ones. The irq output is high exactly while some carry bit is set and its mask bit is 0.
- R11: When a counter write and an increment of the same counter fall in the same cycle, the increment is applied and the write is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txStatValid | input | 1 | One-cycle end-of-frame status strobe |
| txStatLen | input | LEN_W | Frame length in bytes |
| txStatFcsOk | input | 1 | Frame FCS is correct |
| txStatColl | input | COLL_W | Collisions seen by the frame |
| txStatAbort | input | 1 | Frame aborted after excessive collisions |
| txStatCtrl | input | 1 | Type field marks a MAC control frame |
| txStatPause | input | 1 | Pause frame sent and honored |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, combinational from regAddr |
| irq | output | 1 | Unmasked rollover interrupt |

## Verification
The bench builds the block with 8-bit counters behind the default 32-bit register port. This lets both kinds of wrap be reached in a handful of events:
- a single +1 step from a loaded value of 255;
- a collision count that carries out of the adder from 250.

Length stimulus sits on both sides of the 64 and 1518 byte boundaries. The bench also lines up a carry clear with a fresh wrap, and a counter write with an increment, in the same cycle.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  localparam int NUM_CNT = 9;
  localparam int ADDR_W = 4;

  // counter slots; the slot number is the register address and the carry bit
  localparam int IDX_XCOL = 0;
  localparam int IDX_NCOL = 1;
  localparam int IDX_PAUSE = 2;
  localparam int IDX_JABBER = 3;
  localparam int IDX_FCS = 4;
  localparam int IDX_CTRL = 5;
  localparam int IDX_OVER = 6;
  localparam int IDX_UNDER = 7;
  localparam int IDX_FRAG = 8;

  localparam logic [ADDR_W-1:0] ADDR_CARRY = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 4'd10;

  typedef struct packed {
    logic [NUM_CNT-1:0] bump;
    logic [NUM_CNT-1:0] cntWr;
    logic carryClr;
    logic maskWr;
  } stat_ctl_t;
endpackage

// File: rtl/txstat_ctrl.sv
module txstat_ctrl
  import txstat_pkg::*;
#(
  parameter int LEN_W = 14,
  parameter int COLL_W = 5,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic              txStatValid,
  input  logic [LEN_W-1:0]  txStatLen,
  input  logic              txStatFcsOk,
  input  logic [COLL_W-1:0] txStatColl,
  input  logic              txStatAbort,
  input  logic              txStatCtrl,
  input  logic              txStatPause,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output stat_ctl_t         ctl,
  output logic [COLL_W-1:0] collAmt
);
  logic tooShort, tooLong, sizeOk;

  assign tooShort = txStatLen < LEN_W'(MIN_LEN);
  assign tooLong = txStatLen > LEN_W'(MAX_LEN);
  assign sizeOk = !tooShort && !tooLong;
  assign collAmt = txStatColl;

  always_comb begin
    ctl = '0;
    if (txStatValid) begin
      ctl.bump[IDX_XCOL] = txStatAbort;
      ctl.bump[IDX_NCOL] = txStatColl != '0;
      ctl.bump[IDX_UNDER] = tooShort && txStatFcsOk;
      ctl.bump[IDX_FRAG] = tooShort && !txStatFcsOk;
      ctl.bump[IDX_OVER] = tooLong && txStatFcsOk;
      ctl.bump[IDX_JABBER] = tooLong && !txStatFcsOk;
      ctl.bump[IDX_FCS] = sizeOk && !txStatFcsOk;
      ctl.bump[IDX_CTRL] = sizeOk && txStatCtrl;
      ctl.bump[IDX_PAUSE] = sizeOk && txStatFcsOk && txStatCtrl && txStatPause;
    end
    for (int i = 0; i < NUM_CNT; i++)
      ctl.cntWr[i] = regWrEn && (regAddr == ADDR_W'(i));
    ctl.carryClr = regWrEn && (regAddr == ADDR_CARRY);
    ctl.maskWr = regWrEn && (regAddr == ADDR_MASK);
  end
endmodule

// File: rtl/txstat_dp.sv
module txstat_dp
  import txstat_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DATA_W = 32,
  parameter int COLL_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  stat_ctl_t          ctl,
  input  logic [COLL_W-1:0]  collAmt,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_CNT-1:0] carryBits,
  output logic [NUM_CNT-1:0] maskBits,
  output logic               irq
);
  logic [CNT_W-1:0] cntArr [NUM_CNT];
  logic [NUM_CNT-1:0] rollover;
  logic [NUM_CNT-1:0] clrBits;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic [CNT_W:0] sum;
    logic [CNT_W-1:0] cnt;
    if (g == IDX_NCOL) begin : g_addn
      assign sum = {1'b0, cnt} + (CNT_W+1)'(collAmt);
    end else begin : g_add1
      assign sum = {1'b0, cnt} + (CNT_W+1)'(1);
    end
    always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else if (ctl.bump[g]) cnt <= sum[CNT_W-1:0];
      else if (ctl.cntWr[g]) cnt <= regWrData[CNT_W-1:0];
    end
    assign rollover[g] = ctl.bump[g] & sum[CNT_W];
    assign cntArr[g] = cnt;
  end

  assign clrBits = ctl.carryClr ? regWrData[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      carryBits <= '0;
      maskBits <= '1;
    end else begin
      carryBits <= (carryBits & ~clrBits) | rollover;
      if (ctl.maskWr) maskBits <= regWrData[NUM_CNT-1:0];
    end
  end

  assign irq = |(carryBits & ~maskBits);

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (regAddr == ADDR_W'(i)) regRdData = DATA_W'(cntArr[i]);
    if (regAddr == ADDR_CARRY) regRdData = DATA_W'(carryBits);
    if (regAddr == ADDR_MASK) regRdData = DATA_W'(maskBits);
  end
endmodule

// File: rtl/txstat_bank.sv
module txstat_bank
  import txstat_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W = 14,
  parameter int COLL_W = 5,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txStatValid,
  input  logic [LEN_W-1:0]  txStatLen,
  input  logic              txStatFcsOk,
  input  logic [COLL_W-1:0] txStatColl,
  input  logic              txStatAbort,
  input  logic              txStatCtrl,
  input  logic              txStatPause,
  input  logic [3:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);
  stat_ctl_t ctl;
  logic [COLL_W-1:0] collAmt;
  logic [NUM_CNT-1:0] carryBits, maskBits;

  txstat_ctrl #(.LEN_W(LEN_W), .COLL_W(COLL_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_ctrl (
    .txStatValid(txStatValid), .txStatLen(txStatLen), .txStatFcsOk(txStatFcsOk),
    .txStatColl(txStatColl), .txStatAbort(txStatAbort), .txStatCtrl(txStatCtrl),
    .txStatPause(txStatPause), .regAddr(regAddr), .regWrEn(regWrEn),
    .ctl(ctl), .collAmt(collAmt)
  );

  txstat_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W), .COLL_W(COLL_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .collAmt(collAmt), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .carryBits(carryBits),
    .maskBits(maskBits), .irq(irq)
  );
endmodule

// File: rtl/txstat_chk.sv
module txstat_chk
  import txstat_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               txStatValid,
  input logic [3:0]         regAddr,
  input logic               regWrEn,
  input logic [NUM_CNT-1:0] carryBits,
  input logic [NUM_CNT-1:0] maskBits,
  input logic               irq
);
  // R9
  carry_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(regWrEn && regAddr == ADDR_CARRY) |=> ((carryBits & $past(carryBits)) == $past(carryBits)));

  // R9
  carry_source_chk: assert property (@(posedge clk) disable iff (rst)
    !txStatValid |=> ((carryBits & ~$past(carryBits)) == '0));

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (carryBits != '0));

  // R10
  mask_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (&maskBits));

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(regWrEn && regAddr == ADDR_MASK) |=> $stable(maskBits));
endmodule

bind txstat_bank txstat_chk u_chk (
  .clk(clk), .rst(rst), .txStatValid(txStatValid), .regAddr(regAddr),
  .regWrEn(regWrEn), .carryBits(carryBits), .maskBits(maskBits), .irq(irq)
);

// File: tb/tb_txstat_bank.sv
module tb_txstat_bank;
  localparam int CW = 8;
  localparam int DW = 32;
  localparam int LW = 14;
  localparam int KW = 5;

  logic clk = 0, rst = 1;
  logic txStatValid = 0, txStatFcsOk = 0, txStatAbort = 0, txStatCtrl = 0, txStatPause = 0;
  logic [LW-1:0] txStatLen = '0;
  logic [KW-1:0] txStatColl = '0;
  logic [3:0] regAddr = '0;
  logic regWrEn = 0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic irq;

  int errors = 0, checks = 0;
  bit finished = 0;
  int expCnt [9];
  int expCarry = 0, expMask = 'h1FF;

  always #2 clk = ~clk;

  txstat_bank #(.CNT_W(CW), .DATA_W(DW), .LEN_W(LW), .COLL_W(KW)) dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addExp(int idx, int amt);
    expCnt[idx] += amt;
    if (expCnt[idx] >= (1 << CW)) begin
      expCnt[idx] -= (1 << CW);
      expCarry |= (1 << idx);
    end
  endtask

  task automatic cycle(bit doF, int len, bit ok, int coll, bit ab, bit ct, bit pa,
                       bit doW, int addr, int data);
    @(negedge clk);
    txStatValid = doF; txStatLen = LW'(len); txStatFcsOk = ok; txStatColl = KW'(coll);
    txStatAbort = ab; txStatCtrl = ct; txStatPause = pa;
    regWrEn = doW; regAddr = 4'(addr); regWrData = DW'(data);
    @(negedge clk);
    txStatValid = 0; regWrEn = 0;
  endtask

  task automatic frame(int len, bit ok, int coll = 0, bit ab = 0, bit ct = 0, bit pa = 0);
    cycle(1, len, ok, coll, ab, ct, pa, 0, 0, 0);
  endtask

  task automatic wr(int addr, int data);
    cycle(0, 0, 0, 0, 0, 0, 0, 1, addr, data);
  endtask

  task automatic rd(int addr, output int val);
    @(negedge clk);
    regAddr = 4'(addr);
    #1 val = int'(regRdData);
  endtask

  task automatic checkAll(string req);
    int v;
    for (int i = 0; i < 9; i++) begin
      rd(i, v);
      check($sformatf("%s cnt%0d", req, i), v, expCnt[i]);
    end
    rd(9, v); check({req, " carry R9"}, v, expCarry);
    rd(10, v); check({req, " mask R10"}, v, expMask);
    check({req, " irq R10"}, int'(irq), int'((expCarry & ~expMask) != 0));
  endtask

  task automatic t_reset();
    checkAll("R8 reset");
  endtask

  task automatic t_size();
    frame(60, 1); addExp(7, 1);
    frame(63, 0); addExp(8, 1);
    frame(64, 1);
    frame(64, 0); addExp(4, 1);
    frame(1518, 0); addExp(4, 1);
    frame(1519, 1); addExp(6, 1);
    frame(1519, 0); addExp(3, 1);
    frame(1518, 1);
    checkAll("R1 R2 R3 size");
  endtask

  task automatic t_ctrl();
    frame(100, 1, 0, 0, 1, 0); addExp(5, 1);
    frame(100, 1, 0, 0, 1, 1); addExp(5, 1); addExp(2, 1);
    frame(100, 0, 0, 0, 1, 1); addExp(5, 1); addExp(4, 1);
    frame(60, 1, 0, 0, 1, 1); addExp(7, 1);
    frame(100, 1, 0, 0, 0, 1);
    checkAll("R4 R5 control");
  endtask

  task automatic t_coll();
    frame(100, 1, 3); addExp(1, 3);
    frame(100, 1, 16, 1); addExp(1, 16); addExp(0, 1);
    frame(100, 1, 0);
    checkAll("R6 R7 collisions");
  endtask

  task automatic t_wrap();
    int v;
    wr(1, 250); expCnt[1] = 250;
    rd(1, v); check("R8 write load", v, 250);
    frame(100, 1, 10); addExp(1, 10);
    checkAll("R9 adder carry");
    check("R10 masked irq", int'(irq), 0);
    wr(10, 'h1FD); expMask = 'h1FD;
    checkAll("R10 unmask");
    check("R10 irq up", int'(irq), 1);
    wr(9, 0);
    checkAll("R9 write zero keeps");
    wr(9, 2); expCarry = 0;
    checkAll("R9 clear");
    wr(7, 255); expCnt[7] = 255;
    frame(10, 1); addExp(7, 1);
    checkAll("R9 plus one wrap");
  endtask

  task automatic t_setwins();
    wr(7, 255); expCnt[7] = 255;
    cycle(1, 20, 1, 0, 0, 0, 0, 1, 9, 'h80); addExp(7, 1);
    checkAll("R9 set wins over clear");
    wr(10, 'h17F); expMask = 'h17F;
    checkAll("R10 irq bit7");
    wr(9, 'h80); expCarry = 0;
    checkAll("R9 clear bit7");
  endtask

  task automatic t_prio();
    cycle(1, 30, 0, 0, 0, 0, 0, 1, 8, 'h55); addExp(8, 1);
    checkAll("R11 increment wins");
    wr(8, 'h55); expCnt[8] = 'h55;
    checkAll("R11 write alone");
  endtask

  task automatic t_unmapped();
    int v;
    wr(12, 'hFF);
    rd(12, v); check("R8 unmapped read", v, 0);
    checkAll("R8 unmapped write");
  endtask

  initial begin
    for (int i = 0; i < 9; i++) expCnt[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_size();
    t_ctrl();
    t_coll();
    t_wrap();
    t_setwins();
    t_prio();
    t_unmapped();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule